// File: doc/BRIEF.md
# DDR SDRAM Command Timing Sequencer

This block sits on the controller side of a four-bank x16 DDR SDRAM. It turns user requests into the memory's command stream. Each request names a bank, a 12-bit row, a 9-bit column and a direction. The block keeps an open-page record for every bank and decides whether a request is a row hit, a row miss or a closed-bank access. From that it issues ACTIVE, PRECHARGE, READ or WRITE. It holds each command back until every clock-count spacing that applies to it has elapsed. All command pins are registered and change on the rising clock edge. Row and column share one address bus.

After reset the block programs the mode register once. The mode word carries burst length, burst type and read latency. The block then serves requests. A refresh interval counter raises a refresh demand every `REF_CYCLES` clocks. A pending refresh takes priority over user requests. The block closes all open rows with an all-bank precharge, issues AUTO REFRESH, and then keeps every bank idle for the refresh cycle time.

The request port is valid/ready. A requester raises `req_valid` and holds `req_write`, `req_bank`, `req_row` and `req_col` stable until it sees `req_ready` high at a rising edge. `req_ready` is high only in the cycle whose edge issues that request's READ or WRITE. While a precharge, an activate, a refresh or a timing wait is in progress, `req_ready` stays low and the request waits.

Top module: `ddrseq_top`

## Requirements
- R1: Once reset is released, the first command on the pins is MODE REGISTER SET with BA = 0. The address is 0 except for these fields: A[2:0] holds the burst-length code (2→1, 4→2, 8→3), A[3] holds the burst type (1 = interleaved), and A[6:4] holds the read latency. No other command appears until `T_MRD` cycles after it.
- R2: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as follows: ACT 0011, READ 0101, WRITE 0100, PRE 0010, REF 0001, MRS 0000, NOP 0111. During reset and in idle cycles the pins show NOP, and no other pattern ever appears.
- R3: Each accepted request produces exactly one READ (for req_write=0) or WRITE (for req_write=1), in acceptance order. It carries the request's bank on BA and its column on A[8:0], with A[11:9] and A10 low. The row open in that bank at that moment equals the request's row.
- R4: The block keeps a record of open rows. A row hit issues no ACT. A row miss first issues PRE to that bank with A10 low, then issues ACT. A closed bank is activated directly. ACT carries the request's bank and row, and it is only ever issued to a closed bank.
- R5: For the same bank, ACT to ACT is at least `T_RC` (15) cycles, ACT to PRE is at least `T_RAS` (10), and PRE to ACT is at least `T_RP` (5).
- R6: ACT to READ or WRITE in the same bank is at least `T_RCD` (4) cycles.
- R7: WRITE to the next ACT of the same bank is at least `T_DAL` (8) cycles.
- R8: Successive READ/WRITE commands are at least BURST_LEN/2 cycles apart. A READ follows a WRITE by at least BURST_LEN/2+2 cycles, so a write burst is never cut short by a read.
- R9: Within `REF_CYCLES` plus a bounded wait, a refresh demand issues REF. Before it, the block issues a PRE with A10 high if any row is open. REF comes only with all banks closed and at least `T_RP` after the last precharge. No ACT follows REF for `T_RFC` (17) cycles.
- R10: `req_ready` is low except in the cycle that issues the request's READ or WRITE. A held request is neither lost nor duplicated while it waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request's column command issues at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Target column |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | 2 | Bank address |
| sdr_addr | output | 12 | Multiplexed row/column/mode address |

## Verification
The bench builds the block with burst length 4, read latency 3 and interleaved bursts, so the mode word under test is 0x03A. These values also make the column gap 2 cycles and the write-to-read gap 4 cycles. `REF_CYCLES` is set to 150 so that refresh demands land many times in the middle of request traffic. That exercises the precharge-all, REF and refresh-recovery path against open rows and running timers. The timing spacings stay at their defaults, so every clock-count rule is checked at its real value while row hits, row misses and bank switches mix.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;
endpackage

// File: rtl/ddrseq_refresh.sv
module ddrseq_refresh #(
  parameter int REF_CYCLES = 976
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_pend
);
  localparam int CW = $clog2(REF_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= CW'(REF_CYCLES - 1);
      ref_pend <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= CW'(REF_CYCLES - 1);
      else             cnt_q <= cnt_q - 1'b1;
      if (ref_done)    ref_pend <= 1'b0;
      if (cnt_q == '0) ref_pend <= 1'b1;
    end
  end

  // R9: an issued refresh retires the demand
  assert_ref_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && cnt_q != '0) |=> !ref_pend);
endmodule

// File: rtl/ddrseq_bank.sv
module ddrseq_bank #(
  parameter int ROW_W = 12,
  parameter int T_RC  = 15,
  parameter int T_RAS = 10,
  parameter int T_RP  = 5,
  parameter int T_RCD = 4,
  parameter int T_DAL = 8,
  parameter int T_RFC = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_col,
  input  logic             do_wr,
  input  logic             do_ref,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_clr,
  output logic             pre_clr,
  output logic             col_clr
);
  localparam int WR_PRE = (T_DAL > T_RP) ? T_DAL - T_RP : 1;
  localparam int TMAX   = (T_RFC > T_RC) ? T_RFC : T_RC;
  localparam int TW     = $clog2(TMAX + 1);

  logic [TW-1:0] act_t, pre_t, col_t;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] cur, input int val);
    logic [TW-1:0] d;
    d = (cur != '0) ? cur - 1'b1 : '0;
    return (TW'(val) > d) ? TW'(val) : d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_t    <= '0;
      pre_t    <= '0;
      col_t    <= '0;
      is_open  <= 1'b0;
      open_row <= '0;
    end else begin
      act_t <= nxt(act_t, 0);
      pre_t <= nxt(pre_t, 0);
      col_t <= nxt(col_t, 0);
      if (do_act) begin
        act_t    <= nxt(act_t, T_RC - 1);
        pre_t    <= nxt(pre_t, T_RAS - 1);
        col_t    <= nxt(col_t, T_RCD - 1);
        is_open  <= 1'b1;
        open_row <= row_in;
      end
      if (do_pre) begin
        act_t   <= nxt(act_t, T_RP - 1);
        is_open <= 1'b0;
      end
      if (do_wr)  pre_t <= nxt(pre_t, WR_PRE - 1);
      if (do_ref) act_t <= nxt(act_t, T_RFC - 1);
    end
  end

  assign act_clr = (act_t == '0);
  assign pre_clr = (pre_t == '0);
  assign col_clr = is_open && (col_t == '0);

  assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!is_open && act_t == '0));
  assert_pre_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pre && is_open) |-> pre_t == '0);
  assert_col_rcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> (is_open && col_t == '0));
endmodule

// File: rtl/ddrseq_top.sv
module ddrseq_top
  import ddrseq_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int T_RC       = 15,
  parameter int T_RFC      = 17,
  parameter int T_RAS      = 10,
  parameter int T_RP       = 5,
  parameter int T_DAL      = 8,
  parameter int T_RCD      = 4,
  parameter int T_MRD      = 2,
  parameter int BURST_LEN  = 8,
  parameter int CAS_LAT    = 3,
  parameter int INTERLEAVE = 0,
  parameter int TCK_PS     = 8000,
  parameter int REF_CYCLES = 7812000 / TCK_PS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  output logic                     sdr_cs_n,
  output logic                     sdr_ras_n,
  output logic                     sdr_cas_n,
  output logic                     sdr_we_n,
  output logic [$clog2(BANKS)-1:0] sdr_ba,
  output logic [ROW_W-1:0]         sdr_addr
);
  localparam int BA_W    = $clog2(BANKS);
  localparam int AW      = ROW_W;
  localparam int CAS_GAP = BURST_LEN / 2;
  localparam int WR2RD   = BURST_LEN / 2 + 2;
  localparam int BL_CODE = (BURST_LEN == 2) ? 1 : (BURST_LEN == 4) ? 2 : 3;
  localparam logic [AW-1:0] MODE_WORD =
    AW'((CAS_LAT << 4) | ((INTERLEAVE != 0 ? 1 : 0) << 3) | BL_CODE);

  cmd_e            cmd;
  logic            pre_all;
  logic            init_q;
  logic [3:0]      glob_t, cas_t, wtr_t;
  logic [BANKS-1:0] b_open, b_act, b_pre, b_col;
  logic [ROW_W-1:0] b_row [BANKS];
  logic            ref_pend;
  logic [AW-1:0]   addr_d;

  ddrseq_refresh #(.REF_CYCLES(REF_CYCLES)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_done(cmd == CMD_REF), .ref_pend(ref_pend)
  );

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic hit_i;
    assign hit_i = (req_bank == BA_W'(i));
    ddrseq_bank #(
      .ROW_W(ROW_W), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_RCD(T_RCD), .T_DAL(T_DAL), .T_RFC(T_RFC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(cmd == CMD_ACT && hit_i),
      .do_pre(cmd == CMD_PRE && (pre_all || hit_i)),
      .do_col((cmd == CMD_RD || cmd == CMD_WR) && hit_i),
      .do_wr(cmd == CMD_WR && hit_i),
      .do_ref(cmd == CMD_REF),
      .row_in(req_row),
      .is_open(b_open[i]), .open_row(b_row[i]),
      .act_clr(b_act[i]), .pre_clr(b_pre[i]), .col_clr(b_col[i])
    );
  end

  always_comb begin
    cmd       = CMD_NOP;
    pre_all   = 1'b0;
    req_ready = 1'b0;
    if (init_q) begin
      cmd = CMD_MRS;
    end else if (glob_t == '0) begin
      if (ref_pend) begin
        if (|b_open) begin
          if (&(~b_open | b_pre)) begin
            cmd     = CMD_PRE;
            pre_all = 1'b1;
          end
        end else if (&b_act) begin
          cmd = CMD_REF;
        end
      end else if (req_valid) begin
        if (b_open[req_bank] && b_row[req_bank] == req_row) begin
          if (b_col[req_bank] && cas_t == '0 && (req_write || wtr_t == '0)) begin
            cmd       = req_write ? CMD_WR : CMD_RD;
            req_ready = 1'b1;
          end
        end else if (b_open[req_bank]) begin
          if (b_pre[req_bank]) cmd = CMD_PRE;
        end else if (b_act[req_bank]) begin
          cmd = CMD_ACT;
        end
      end
    end
  end

  always_comb begin
    case (cmd)
      CMD_MRS: addr_d = MODE_WORD;
      CMD_ACT: addr_d = req_row;
      CMD_RD, CMD_WR: addr_d = AW'(req_col);
      CMD_PRE: addr_d = pre_all ? AW'(1 << 10) : '0;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= 1'b1;
      glob_t   <= '0;
      cas_t    <= '0;
      wtr_t    <= '0;
      {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} <= CMD_NOP;
      sdr_ba   <= '0;
      sdr_addr <= '0;
    end else begin
      if (cmd == CMD_MRS) begin
        init_q <= 1'b0;
        glob_t <= 4'(T_MRD - 1);
      end else if (glob_t != '0) begin
        glob_t <= glob_t - 1'b1;
      end
      if (cmd == CMD_RD || cmd == CMD_WR) cas_t <= 4'(CAS_GAP - 1);
      else if (cas_t != '0)               cas_t <= cas_t - 1'b1;
      if (cmd == CMD_WR)                  wtr_t <= 4'(WR2RD - 1);
      else if (wtr_t != '0)               wtr_t <= wtr_t - 1'b1;
      {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} <= cmd;
      sdr_ba   <= (cmd == CMD_MRS || cmd == CMD_REF || pre_all) ? '0 : req_bank;
      sdr_addr <= addr_d;
    end
  end

  assert_ready_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!sdr_cs_n && sdr_ras_n && !sdr_cas_n));
  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n) |-> (b_open == '0));
  assert_mrs_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_q) |=> !(!sdr_ras_n && !sdr_cas_n && !sdr_we_n && $past(!init_q)));
endmodule

// File: tb/ddrseq_top_tb.sv
module ddrseq_top_tb;
  localparam int BL = 4, CL = 3, REFC = 150;
  localparam int TRC = 15, TRFC = 17, TRAS = 10, TRP = 5, TDAL = 8, TRCD = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [8:0] req_col = 0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;

  always #4 clk = ~clk;

  ddrseq_top #(.BURST_LEN(BL), .CAS_LAT(CL), .INTERLEAVE(1), .REF_CYCLES(REFC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .sdr_cs_n(cs_n), .sdr_ras_n(ras_n), .sdr_cas_n(cas_n), .sdr_we_n(we_n),
    .sdr_ba(ba), .sdr_addr(addr)
  );

  typedef struct packed { logic wr; logic [1:0] bank; logic [11:0] row; logic [8:0] col; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, accepted = 0, issued = 0, refs = 0;
  logic [1:0] cur_bank = 0;
  logic [11:0] cur_row = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: holds the request until ready, pushes expected column command
  task automatic send(input logic wr, input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
    bit done = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = b; req_row = r; req_col = c;
    cur_bank = b; cur_row = r;
    while (!done) begin
      #1;
      if (req_ready) begin
        q.push_back('{wr, b, r, c});
        accepted++;
        done = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  // monitor / scoreboard
  int cyc = 0, mrs_c = -1, last_ref = 0;
  int l_act[4], l_pre[4], l_wr[4];
  bit open_b[4];
  logic [11:0] row_b[4];
  int l_cas = -1000, l_wrany = -1000;

  initial begin
    for (int i = 0; i < 4; i++) begin
      l_act[i] = -1000; l_pre[i] = -1000; l_wr[i] = -1000; open_b[i] = 0; row_b[i] = 0;
    end
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "NOP during reset", {cs_n, ras_n, cas_n, we_n}, 7);
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      case ({cs_n, ras_n, cas_n, we_n})
        4'b0111: ;
        4'b0000: begin
          chk(mrs_c < 0, "R1", "single MRS first", mrs_c, -1);
          chk(addr == 12'h03A && ba == 0, "R1", "mode word", addr, 12'h03A);
          mrs_c = cyc;
        end
        4'b0011: begin
          chk(mrs_c >= 0 && cyc - mrs_c >= 2, "R1", "gap after MRS", cyc - mrs_c, 2);
          chk(!open_b[ba], "R4", "ACT to closed bank", open_b[ba], 0);
          chk(ba == cur_bank && addr == cur_row, "R4", "ACT bank/row", addr, cur_row);
          chk(cyc - l_act[ba] >= TRC, "R5", "ACT-ACT", cyc - l_act[ba], TRC);
          chk(cyc - l_pre[ba] >= TRP, "R5", "PRE-ACT", cyc - l_pre[ba], TRP);
          chk(cyc - l_wr[ba] >= TDAL, "R7", "WR-ACT", cyc - l_wr[ba], TDAL);
          chk(cyc - last_ref >= TRFC || refs == 0, "R9", "REF-ACT", cyc - last_ref, TRFC);
          open_b[ba] = 1; row_b[ba] = addr; l_act[ba] = cyc;
        end
        4'b0010: begin
          for (int b = 0; b < 4; b++) begin
            if (addr[10] || b == ba) begin
              if (open_b[b])
                chk(cyc - l_act[b] >= TRAS, "R5", "ACT-PRE", cyc - l_act[b], TRAS);
              else if (!addr[10])
                chk(0, "R4", "PRE to closed bank", b, -1);
              open_b[b] = 0; l_pre[b] = cyc;
            end
          end
        end
        4'b0101, 4'b0100: begin
          exp_t e;
          issued++;
          chk(open_b[ba], "R4", "column cmd to open bank", open_b[ba], 1);
          chk(cyc - l_act[ba] >= TRCD, "R6", "ACT-col", cyc - l_act[ba], TRCD);
          chk(cyc - l_cas >= BL / 2, "R8", "col-col", cyc - l_cas, BL / 2);
          if (we_n)
            chk(cyc - l_wrany >= BL / 2 + 2, "R8", "WR-RD", cyc - l_wrany, BL / 2 + 2);
          if (q.size() == 0) begin
            chk(0, "R3", "unexpected column cmd", ba, -1);
          end else begin
            e = q.pop_front();
            chk(e.wr == !we_n, "R3", "direction", !we_n, e.wr);
            chk(ba == e.bank && addr == {3'b000, e.col}, "R3", "bank/col", addr, e.col);
            chk(row_b[ba] == e.row, "R3", "open row", row_b[ba], e.row);
          end
          l_cas = cyc;
          if (!we_n) begin l_wrany = cyc; l_wr[ba] = cyc; end
        end
        4'b0001: begin
          for (int b = 0; b < 4; b++) begin
            chk(!open_b[b], "R9", "bank closed at REF", b, -1);
            chk(cyc - l_pre[b] >= TRP, "R9", "PRE-REF", cyc - l_pre[b], TRP);
          end
          chk(cyc - last_ref <= REFC + 40, "R9", "refresh interval", cyc - last_ref, REFC);
          last_ref = cyc; refs++;
        end
        default: chk(0, "R2", "illegal encoding", {cs_n, ras_n, cas_n, we_n}, 7);
      endcase
    end
  end

  // R10: ready only while a request is offered
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      #2;
      if (req_ready && !req_valid) chk(0, "R10", "ready without request", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WATCHDOG", "run hung", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    send(1, 0, 12'd5, 9'd3);       // closed bank write
    send(0, 0, 12'd5, 9'd3);       // hit, read after write (R8)
    send(0, 0, 12'd5, 9'd4);       // back-to-back read
    send(0, 0, 12'd9, 9'd7);       // miss (R4)
    send(1, 1, 12'hFFF, 9'h1FF);   // extreme row/col (R3)
    send(1, 2, 12'd0, 9'd0);
    send(0, 3, 12'd77, 9'd100);
    send(0, 1, 12'd1, 9'd2);       // miss after write (R7)
    repeat (400) @(negedge clk);   // idle refreshes
    lf = 16'hACE1;
    for (int n = 0; n < 120; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[15], lf[1:0], {9'd0, lf[4:2]}, lf[13:5]);
    end
    repeat (60) @(negedge clk);
    chk(q.size() == 0, "R3", "all requests issued", q.size(), 0);
    chk(accepted == issued, "R10", "accept count", issued, accepted);
    chk(refs >= 4, "R9", "refreshes seen", refs, 4);
    summary();
  end
endmodule